// File: doc/BRIEF.md
# Path-Hashed Perceptron Direction Predictor

This block predicts whether a conditional branch is taken. It keeps a bias weight per program-counter slot and a two-dimensional weight table, plus a circular record of recent branch outcomes and targets. The record is 64 entries deep and is read newest-first in eight groups of eight. Each group selects its own row of the weight table by XOR-folding the shifted program counter with the shifted targets stored in that group. Each history position then adds or subtracts its weight, depending on whether that position was taken. The bias weight is added to the same total. A sum of zero or more means "taken".

A client offers a program counter and a branch target on the predict handshake. After a fixed number of cycles the block pulses a done strobe with the direction and the signed sum. At that point the predicted outcome and the target enter the history. The block then waits for the resolved outcome on the train handshake. Training adjusts the bias and the 64 selected weights, using the state captured when the prediction was made, and only when the prediction was wrong or the sum was weak.

The control sequence has four states:
- IDLE accepts a prediction. A train offer made here is ignored.
- ACCUM folds in one history group per cycle and moves to REPORT after the last group.
- REPORT raises the done strobe, pushes the history and moves to AWAIT.
- AWAIT accepts the outcome, updates the weights and returns to IDLE.

Top module: `hp_predictor`

## Requirements
- R1: After reset every weight, every history taken bit and target, and the history pointer are zero, so the first prediction reports a sum of 0 and taken; `pred_ready` and `train_ready` are 1 and `pred_done` is 0.
- R2: The bias weight is selected by program-counter bits [13:4], that is (pc >> 4) mod 1024, so two counters differing only above bit 13 share a bias weight.
- R3: History position k (k = 0 newest … 63 oldest) is the entry at (pointer − 1 − k) mod 64; group g covers positions 8g … 8g+7, and weight column equals k.
- R4: The row for group g is ((pc >> 4) XOR the eight (target >> 4) values of that group) mod ROWS (default ROWS = 32).
- R5: The reported sum is the bias weight plus, over all 64 positions, +w when that position is taken and −w otherwise; `pred_taken` is 1 exactly when the sum is ≥ 0.
- R6: `pred_done` is a one-cycle pulse that rises 9 cycles after the accepting clock edge (8 ACCUM cycles, then REPORT); `pred_sum` and `pred_taken` are valid while it is high.
- R7: In the cycle after REPORT, the predicted direction and the target are written at the pointer and the pointer advances by one modulo 64; from acceptance until a train is accepted, `pred_ready` is 0.
- R8: Training uses the history as it stood before the push: each selected weight moves +1 when its saved taken bit equals the actual outcome and −1 otherwise.
- R9: Weights saturate: an increment at 127 and a decrement at −128 leave the weight unchanged.
- R10: Training happens only when the outcome differs from the prediction or |sum| ≤ 29 (floor(1.93·8 + 14)).
- R11: When training happens, the bias weight moves +1 for a taken outcome and −1 for not taken, with the same saturation.
- R12: A train offer while no prediction is pending changes no weight and no history; `pred_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_valid | input | 1 | Prediction request offered |
| pred_ready | output | 1 | Block can accept a prediction (IDLE) |
| pred_pc | input | 32 | Branch program counter |
| pred_target | input | 32 | Branch target recorded in history |
| pred_done | output | 1 | Result strobe, one cycle |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_sum | output | 16 | Signed perceptron sum |
| train_valid | input | 1 | Resolved outcome offered |
| train_ready | output | 1 | Block accepts an outcome (IDLE or AWAIT) |
| train_taken | input | 1 | Actual branch direction |

## Verification
The assertions assume the following about the inputs:
- A client raises `pred_valid` only to have it sampled against `pred_ready`.
- Only one prediction is outstanding at a time, because the block holds `pred_ready` low until it has been trained.
- `pred_pc` and `pred_target` matter only on the accepting edge.

The stimulus drives every input on the falling edge and holds each request for exactly one rising edge. It always resolves a prediction with one train offer before the next predict. It also sends deliberate train offers while idle, and it keeps the outcome stream within these rules while mixing random, constant and always-wrong outcomes.

// File: rtl/hp_pkg.sv
package hp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_REPORT,
        ST_AWAIT
    } hp_state_e;
endpackage

// File: rtl/hp_path_hist.sv
module hp_path_hist #(
    parameter int DEPTH = 64,
    parameter int TW = 32,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       push_taken,
    input  logic [TW-1:0]              push_tgt,
    output logic [PW-1:0]              wr_ptr,
    output logic [DEPTH-1:0]           taken_q,
    output logic [DEPTH-1:0][TW-1:0]   tgt_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            taken_q <= '0;
            tgt_q   <= '0;
        end else if (push) begin
            taken_q[wr_ptr] <= push_taken;
            tgt_q[wr_ptr]   <= push_tgt;
            wr_ptr          <= wr_ptr + PW'(1);
        end
    end
endmodule

// File: rtl/hp_weight_store.sv
module hp_weight_store #(
    parameter int ROWS = 32,
    parameter int COLS = 64,
    parameter int SEG_LEN = 8,
    parameter int BIAS_N = 1024,
    parameter int W_W = 8,
    localparam int SEGS = COLS / SEG_LEN,
    localparam int RW = $clog2(ROWS),
    localparam int BW = $clog2(BIAS_N),
    localparam int CW = $clog2(SEGS),
    localparam int KW = $clog2(COLS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [BW-1:0]                    rd_bias_idx,
    output logic [W_W-1:0]                   rd_bias_w,
    input  logic [RW-1:0]                    rd_row,
    input  logic [CW-1:0]                    rd_seg,
    output logic [SEG_LEN-1:0][W_W-1:0]      rd_seg_w,
    input  logic                             trn_en,
    input  logic                             trn_dir,
    input  logic [BW-1:0]                    trn_bias_idx,
    input  logic [SEGS-1:0][RW-1:0]          trn_rows,
    input  logic [COLS-1:0]                  trn_agree
);
    localparam logic signed [W_W-1:0] W_MAX = {1'b0, {(W_W-1){1'b1}}};
    localparam logic signed [W_W-1:0] W_MIN = {1'b1, {(W_W-1){1'b0}}};

    logic signed [W_W-1:0] wt   [ROWS][COLS];
    logic signed [W_W-1:0] bias [BIAS_N];

    function automatic logic signed [W_W-1:0] sat_step(input logic signed [W_W-1:0] w,
                                                        input logic up);
        if (up) return (w == W_MAX) ? w : w + W_W'(1);
        else    return (w == W_MIN) ? w : w - W_W'(1);
    endfunction

    assign rd_bias_w = bias[rd_bias_idx];

    for (genvar j = 0; j < SEG_LEN; j++) begin : g_rd
        assign rd_seg_w[j] = wt[rd_row][KW'(int'(rd_seg) * SEG_LEN + j)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++)
                    wt[r][c] <= '0;
            for (int b = 0; b < BIAS_N; b++)
                bias[b] <= '0;
        end else if (trn_en) begin
            bias[trn_bias_idx] <= sat_step(bias[trn_bias_idx], trn_dir);
            for (int s = 0; s < SEGS; s++)
                for (int j = 0; j < SEG_LEN; j++)
                    wt[trn_rows[s]][KW'(s * SEG_LEN + j)] <=
                        sat_step(wt[trn_rows[s]][KW'(s * SEG_LEN + j)],
                                 trn_agree[s * SEG_LEN + j]);
        end
    end
endmodule

// File: rtl/hp_predictor.sv
module hp_predictor
    import hp_pkg::*;
#(
    parameter int PC_W = 32,
    parameter int HIST = 64,
    parameter int SEG_LEN = 8,
    parameter int ROWS = 32,
    parameter int BIAS_N = 1024,
    parameter int W_W = 8,
    parameter int SUM_W = 16,
    parameter int THETA = (193 * SEG_LEN + 1400) / 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_valid,
    output logic              pred_ready,
    input  logic [PC_W-1:0]   pred_pc,
    input  logic [PC_W-1:0]   pred_target,
    output logic              pred_done,
    output logic              pred_taken,
    output logic [SUM_W-1:0]  pred_sum,
    input  logic              train_valid,
    output logic              train_ready,
    input  logic              train_taken
);
    localparam int SEGS = HIST / SEG_LEN;
    localparam int PW = $clog2(HIST);
    localparam int RW = $clog2(ROWS);
    localparam int BW = $clog2(BIAS_N);
    localparam int CW = $clog2(SEGS);

    hp_state_e state_q, state_d;

    logic [CW-1:0]             seg_q;
    logic [PC_W-1:0]           pc_q, tgt_q;
    logic signed [SUM_W-1:0]   acc_q;
    logic [SEGS-1:0][RW-1:0]   rows_q;
    logic [BW-1:0]             bidx_q;
    logic [PW-1:0]             sptr_q;
    logic                      old_bit_q;
    logic                      guess_q;

    logic [PW-1:0]              hist_ptr;
    logic [HIST-1:0]            hist_taken;
    logic [HIST-1:0][PC_W-1:0]  hist_tgt;
    logic [W_W-1:0]             bias_w;
    logic [SEG_LEN-1:0][W_W-1:0] seg_w;

    logic [PW-1:0]             ent [SEG_LEN];
    logic [PC_W-1:0]           fold;
    logic [RW-1:0]             row;
    logic signed [SUM_W-1:0]   wext [SEG_LEN];
    logic signed [SUM_W-1:0]   seg_sum;
    logic [HIST-1:0]           agree;
    logic signed [SUM_W-1:0]   mag;
    logic                      need_train;
    logic                      trn_en;
    logic                      accept;

    assign accept = (state_q == ST_IDLE) && pred_valid;

    hp_path_hist #(.DEPTH(HIST), .TW(PC_W)) u_hist (
        .clk(clk), .rst_n(rst_n),
        .push(state_q == ST_REPORT),
        .push_taken(~acc_q[SUM_W-1]),
        .push_tgt(tgt_q),
        .wr_ptr(hist_ptr),
        .taken_q(hist_taken),
        .tgt_q(hist_tgt)
    );

    hp_weight_store #(.ROWS(ROWS), .COLS(HIST), .SEG_LEN(SEG_LEN),
                      .BIAS_N(BIAS_N), .W_W(W_W)) u_wts (
        .clk(clk), .rst_n(rst_n),
        .rd_bias_idx(pred_pc[BW+3:4]),
        .rd_bias_w(bias_w),
        .rd_row(row),
        .rd_seg(seg_q),
        .rd_seg_w(seg_w),
        .trn_en(trn_en),
        .trn_dir(train_taken),
        .trn_bias_idx(bidx_q),
        .trn_rows(rows_q),
        .trn_agree(agree)
    );

    // one history group: row hash and signed contribution
    always_comb begin
        fold = pc_q >> 4;
        seg_sum = '0;
        for (int j = 0; j < SEG_LEN; j++) begin
            ent[j] = hist_ptr - PW'(1) - PW'(int'(seg_q) * SEG_LEN + j);
            fold = fold ^ (hist_tgt[ent[j]] >> 4);
        end
        for (int j = 0; j < SEG_LEN; j++) begin
            wext[j] = SUM_W'($signed(seg_w[j]));
            seg_sum = hist_taken[ent[j]] ? seg_sum + wext[j] : seg_sum - wext[j];
        end
        row = fold[RW-1:0];
    end

    // training decision against the pre-push history
    always_comb begin
        for (int k = 0; k < HIST; k++)
            agree[k] = ((k == HIST - 1) ? old_bit_q
                        : hist_taken[sptr_q - PW'(1) - PW'(k)]) == train_taken;
        mag = acc_q[SUM_W-1] ? -acc_q : acc_q;
        need_train = (train_taken != guess_q) || (mag <= SUM_W'(THETA));
        trn_en = (state_q == ST_AWAIT) && train_valid && need_train;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (pred_valid) state_d = ST_ACCUM;
            ST_ACCUM:  if (seg_q == CW'(SEGS - 1)) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_AWAIT;
            ST_AWAIT:  if (train_valid) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q     <= '0;
            pc_q      <= '0;
            tgt_q     <= '0;
            acc_q     <= '0;
            rows_q    <= '0;
            bidx_q    <= '0;
            sptr_q    <= '0;
            old_bit_q <= 1'b0;
            guess_q   <= 1'b0;
        end else begin
            if (accept) begin
                pc_q   <= pred_pc;
                tgt_q  <= pred_target;
                bidx_q <= pred_pc[BW+3:4];
                acc_q  <= SUM_W'($signed(bias_w));
                seg_q  <= '0;
            end
            if (state_q == ST_ACCUM) begin
                acc_q         <= acc_q + seg_sum;
                rows_q[seg_q] <= row;
                seg_q         <= seg_q + CW'(1);
            end
            if (state_q == ST_REPORT) begin
                sptr_q    <= hist_ptr;
                old_bit_q <= hist_taken[hist_ptr];
                guess_q   <= ~acc_q[SUM_W-1];
            end
        end
    end

    always_comb begin
        pred_ready  = (state_q == ST_IDLE);
        train_ready = (state_q == ST_IDLE) || (state_q == ST_AWAIT);
        pred_done   = (state_q == ST_REPORT);
        pred_taken  = ~acc_q[SUM_W-1];
        pred_sum    = acc_q;
    end
endmodule

// File: rtl/hp_predictor_chk.sv
module hp_predictor_chk #(
    parameter int PW = 6,
    parameter int SUM_W = 16,
    parameter int LIM = 8320
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pred_valid,
    input logic             pred_ready,
    input logic             pred_done,
    input logic [SUM_W-1:0] pred_sum,
    input logic             train_ready,
    input logic [PW-1:0]    hist_ptr
);
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pred_done |=> !pred_done);

    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && pred_ready) |=> !pred_ready);

    p_pending_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pred_done |=> (!pred_ready && train_ready));

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pred_done |=> hist_ptr == $past(hist_ptr) + PW'(1));

    p_ptr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_done |=> $stable(hist_ptr));

    p_sum_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pred_done |-> ($signed(pred_sum) <= LIM && $signed(pred_sum) >= -LIM));
endmodule

bind hp_predictor hp_predictor_chk #(
    .PW(PW), .SUM_W(SUM_W), .LIM((HIST + 1) * (2 ** (W_W - 1)))
) u_chk (
    .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_ready(pred_ready),
    .pred_done(pred_done), .pred_sum(pred_sum), .train_ready(train_ready),
    .hist_ptr(hist_ptr)
);

// File: tb/hp_predictor_bench.sv
module hp_predictor_bench;
    localparam int HIST = 64;
    localparam int SEGN = 8;
    localparam int ROWS = 32;
    localparam int BIASN = 1024;
    localparam int THETA = 29;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pred_valid = 1'b0;
    logic        pred_ready;
    logic [31:0] pred_pc = '0;
    logic [31:0] pred_target = '0;
    logic        pred_done;
    logic        pred_taken;
    logic [15:0] pred_sum;
    logic        train_valid = 1'b0;
    logic        train_ready;
    logic        train_taken = 1'b0;

    always #4 clk = ~clk;

    hp_predictor u_hp_predictor (
        .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_ready(pred_ready),
        .pred_pc(pred_pc), .pred_target(pred_target), .pred_done(pred_done),
        .pred_taken(pred_taken), .pred_sum(pred_sum), .train_valid(train_valid),
        .train_ready(train_ready), .train_taken(train_taken)
    );

    int nvec = 0;
    int nerr = 0;
    int clamps = 0;

    // reference model state
    int          m_bias [BIASN];
    int          m_w [ROWS][HIST];
    bit          m_ht [HIST];
    int unsigned m_tg [HIST];
    int          m_ptr;
    bit          s_ht [HIST];
    int          s_ptr, s_bidx, s_sum;
    int          s_row [SEGN];
    bit          s_guess, pending;
    bit          last_guess;

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        if (v > 127) begin clamps++; return 127; end
        if (v < -128) begin clamps++; return -128; end
        return v;
    endfunction

    function automatic int model_predict(input int unsigned pc, input int unsigned tg);
        int sum, k, e;
        int unsigned z;
        s_bidx = (pc >> 4) % BIASN;
        sum = m_bias[s_bidx];
        for (int s = 0; s < HIST / SEGN; s++) begin
            z = pc >> 4;
            for (int j = 0; j < SEGN; j++) begin
                e = (m_ptr - 1 - (s * SEGN + j) + 2 * HIST) % HIST;
                z = z ^ (m_tg[e] >> 4);
            end
            s_row[s] = z % ROWS;
            for (int j = 0; j < SEGN; j++) begin
                k = s * SEGN + j;
                e = (m_ptr - 1 - k + 2 * HIST) % HIST;
                sum += m_ht[e] ? m_w[s_row[s]][k] : -m_w[s_row[s]][k];
            end
        end
        for (int i = 0; i < HIST; i++) s_ht[i] = m_ht[i];
        s_ptr = m_ptr;
        s_sum = sum;
        s_guess = (sum >= 0);
        m_ht[m_ptr] = s_guess;
        m_tg[m_ptr] = tg;
        m_ptr = (m_ptr + 1) % HIST;
        pending = 1'b1;
        return sum;
    endfunction

    function automatic void model_train(input bit act);
        int k, e, mg;
        if (!pending) return;
        pending = 1'b0;
        mg = (s_sum < 0) ? -s_sum : s_sum;
        if (act == s_guess && mg > THETA) return;
        m_bias[s_bidx] = sat(m_bias[s_bidx] + (act ? 1 : -1));
        for (int s = 0; s < HIST / SEGN; s++)
            for (int j = 0; j < SEGN; j++) begin
                k = s * SEGN + j;
                e = (s_ptr - 1 - k + 2 * HIST) % HIST;
                m_w[s_row[s]][k] = sat(m_w[s_row[s]][k] + ((s_ht[e] == act) ? 1 : -1));
            end
    endfunction

    task automatic do_pred(input int unsigned pc, input int unsigned tg, input string req);
        int exp_sum;
        exp_sum = model_predict(pc, tg);
        last_guess = (exp_sum >= 0);
        chk("R7 ready before predict", int'(pred_ready), 1);
        pred_valid = 1'b1; pred_pc = pc; pred_target = tg;
        @(posedge clk);
        @(negedge clk);
        pred_valid = 1'b0;
        for (int c = 1; c <= SEGN + 1; c++) begin
            chk("R6 done timing", int'(pred_done), (c == SEGN + 1) ? 1 : 0);
            chk("R7 ready low while busy", int'(pred_ready), 0);
            if (c == SEGN + 1) begin
                chk({req, " sum"}, int'($signed(pred_sum)), exp_sum);
                chk("R5 direction", int'(pred_taken), (exp_sum >= 0) ? 1 : 0);
            end
            @(negedge clk);
        end
        chk("R6 done drops", int'(pred_done), 0);
        chk("R7 pending blocks predict", int'(pred_ready), 0);
        chk("R7 train accepted", int'(train_ready), 1);
    endtask

    task automatic do_train(input bit act, input string req);
        model_train(act);
        train_valid = 1'b1; train_taken = act;
        @(posedge clk);
        @(negedge clk);
        train_valid = 1'b0;
        chk({req, " back to idle"}, int'(pred_ready), 1);
        chk("R12 no done after train", int'(pred_done), 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int unsigned pcs [4];
        int unsigned pc, tg;
        bit act;
        for (int i = 0; i < BIASN; i++) m_bias[i] = 0;
        for (int r = 0; r < ROWS; r++) for (int c = 0; c < HIST; c++) m_w[r][c] = 0;
        for (int i = 0; i < HIST; i++) begin m_ht[i] = 0; m_tg[i] = 0; end
        m_ptr = 0; pending = 0;
        pcs[0] = 32'h0000_1230; pcs[1] = 32'h0040_0a70;
        pcs[2] = 32'h1234_5670; pcs[3] = 32'h0000_3ff0;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pred_ready", int'(pred_ready), 1);
        chk("R1 train_ready", int'(train_ready), 1);
        chk("R1 pred_done", int'(pred_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", int'(pred_ready), 1);

        // R1/R5: all-zero state predicts taken with sum 0
        do_pred(32'h0000_1000, 32'h0000_2000, "R1 first");
        do_train(1'b0, "R8 R11 mispredict train");

        // R12: train offer with nothing pending is ignored
        do_train(1'b1, "R12 ignored train");
        do_train(1'b1, "R12 ignored train again");
        do_pred(32'h0000_1000, 32'h0000_2000, "R12 weights unchanged");
        do_train(1'b1, "R8 train");

        // R2: counters differing above bit 13 alias the bias weight
        do_pred(32'h0000_5550, 32'h0000_0100, "R2 base");
        do_train(1'b1, "R11 bias up");
        do_pred(32'h0000_5550 + (32'd1 << 14), 32'h0000_0100, "R2 alias");
        do_train(1'b1, "R11 bias up alias");

        // R10: constant outcome, training stops once confident
        for (int i = 0; i < 40; i++) begin
            do_pred(32'h0000_7770, 32'h0000_8880, "R10 steady");
            do_train(1'b1, "R10 gated train");
        end

        // R3 R4 R8: random targets and outcomes over a few counters
        for (int i = 0; i < 300; i++) begin
            pc = pcs[$urandom_range(0, 3)];
            tg = $urandom;
            act = 1'($urandom_range(0, 1));
            do_pred(pc, tg, "R3 R4 random");
            do_train(act, "R8 random train");
        end

        // R9: adversarial outcomes keep training active
        for (int i = 0; i < 300; i++) begin
            pc = pcs[i % 2];
            do_pred(pc, 32'h0000_4440, "R9 adversarial");
            do_train(!last_guess, "R9 saturating train");
        end
        $display("model saturation events: %0d", clamps);

        // R12 once more after long run
        do_train(1'b0, "R12 late ignored train");
        do_pred(pcs[0], 32'h0000_0010, "R12 late check");
        do_train(1'b1, "R8 final train");

        finish_run();
    end
endmodule